// File: doc/BRIEF.md
# Selectable PRBS Test Pattern Generator

This block produces a serial pseudorandom bit stream for bit-error testing of a link. A 3-bit select code chooses the sequence. Four codes give plain maximal-length sequences of period 2^7-1, 2^9-1, 2^11-1 and 2^15-1. One code gives a 2^20-1 quasi-random variant that never emits more than fourteen zeros in a row. The remaining three codes are reserved, and the output idles at one for them.

A host starts a pattern by raising a load control. On the rising edge the block captures the select code and seeds the shift register with all ones. Holding the load control high does nothing further; a new load needs the control to return low first. An invert control flips every outgoing bit. The stream side is consumer-paced. The current bit is always presented on `dout`, which makes it permanently valid. The consumer raises `bit_en` in each cycle it takes that bit, so `bit_en` acts as the ready strobe. While `bit_en` is low the stream stalls and no bit is lost or skipped.

Top module: `prbs_pattern_gen`

## Requirements
- R1: The select code captured at load picks the generator: 000 uses x^7+x^6+1, 111 uses x^9+x^5+1, 001 uses x^11+x^9+1 and 010 uses x^15+x^14+1. With N the degree and T the middle tap, each emitted bit is b[k] = b[k-N] xor b[k-T]. The N bits present right after a seed count as earlier bits, all equal to one.
- R2: Select code 011 runs x^20+x^17+1 in the same way. If the emitted bit would be the 15th zero in a row, it is forced to one. The forcing does not alter the recurrence, so at most 14 consecutive zeros ever appear.
- R3: Only a low-to-high transition of `load_req`, as sampled on the clock, captures `pat_sel`. Keeping `load_req` high gives no further load, and changing `pat_sel` without a load edge has no effect.
- R4: A load seeds all ones and clears the zero-run count. The first bit shown in the cycle after the load edge is therefore 0 in every pseudorandom mode.
- R5: The pattern advances by exactly one bit for each cycle in which `bit_en` is high, and holds otherwise. In a cycle that also carries a load edge, the load wins and no advance happens.
- R6: Reserved codes 100, 101 and 110 make the pattern bit a constant one. `bit_en` has no effect in these modes.
- R7: When `inv_en` is 1, `dout` is the complement of the pattern bit in the same cycle. When `inv_en` is 0, the bit passes unchanged.
- R8: After reset the mode is 000 with an all-ones seed and a cleared zero-run count, so `dout` shows 0 when `inv_en` is 0.
- R9: The shift register never reaches all zeros. The 2^7-1 and 2^9-1 streams repeat with periods of exactly 127 and 511 taken bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Consumer takes the current bit this cycle (ready strobe) |
| load_req | input | 1 | Host load control, acts on its rising edge |
| pat_sel | input | 3 | Pattern select code, captured on a load edge |
| inv_en | input | 1 | Invert the outgoing stream |
| dout | output | 1 | Serial pattern bit, always valid |

## Verification
`dout` depends combinationally on the state and on `inv_en`, so an invert change appears in the same cycle, before the next edge. A load edge or a taken bit changes `dout` one cycle later, with one register in the path. The bench drives inputs just after the falling edge, compares `dout` 1 ns later against a history-queue model, and then updates that model at the rising edge with the same inputs. Every bit is therefore checked in the cycle it is offered. Periods and zero runs are also checked at the port, over whole captured stretches of the stream.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int STATE_W = 20;
  localparam int IDX_W   = $clog2(STATE_W + 1);

  typedef enum logic [2:0] {
    SEL_P7   = 3'b000,
    SEL_P11  = 3'b001,
    SEL_P15  = 3'b010,
    SEL_QRSS = 3'b011,
    SEL_RSV4 = 3'b100,
    SEL_RSV5 = 3'b101,
    SEL_RSV6 = 3'b110,
    SEL_P9   = 3'b111
  } pat_sel_e;

  typedef struct packed {
    logic             active;
    logic             qrss;
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] tap;
  } poly_t;

  function automatic poly_t decode_sel(pat_sel_e s);
    poly_t p;
    p.active = 1'b1;
    p.qrss   = 1'b0;
    case (s)
      SEL_P7:   begin p.len = IDX_W'(7);  p.tap = IDX_W'(6);  end
      SEL_P9:   begin p.len = IDX_W'(9);  p.tap = IDX_W'(5);  end
      SEL_P11:  begin p.len = IDX_W'(11); p.tap = IDX_W'(9);  end
      SEL_P15:  begin p.len = IDX_W'(15); p.tap = IDX_W'(14); end
      SEL_QRSS: begin p.len = IDX_W'(20); p.tap = IDX_W'(17); p.qrss = 1'b1; end
      default:  begin p.len = IDX_W'(7);  p.tap = IDX_W'(6);  p.active = 1'b0; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/prbs_edge_det.sv
module prbs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;

  // R3: a held-high control never produces two load pulses in a row
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  seed,
  input  logic  step,
  input  poly_t poly,
  output logic  fb_bit
);

  localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] mask;
  logic [IDX_W-1:0]   hi_idx;
  logic [IDX_W-1:0]   mid_idx;

  always_comb begin
    mask    = (ONE << poly.len) - ONE;
    hi_idx  = poly.len - IDX_W'(1);
    mid_idx = poly.tap - IDX_W'(1);
    fb_bit  = state_q[hi_idx] ^ state_q[mid_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '1;
    else if (seed) state_q <= '1;
    else if (step) state_q <= ((state_q << 1) | {{(STATE_W-1){1'b0}}, fb_bit}) & mask;
  end

  // R5: without a step or a seed the register holds
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !seed) |=> $stable(state_q));

  // R9: the active part of the register never reaches all zeros
  assert_never_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & mask) != '0);

endmodule

// File: rtl/prbs_zero_limit.sv
module prbs_zero_limit #(
  parameter int ZERO_LIMIT = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic qrss_en,
  input  logic raw_bit,
  output logic bit_out
);

  localparam int RUN_W = $clog2(ZERO_LIMIT + 1);

  logic [RUN_W-1:0] run_q;
  logic             at_limit;

  assign at_limit = (run_q == RUN_W'(ZERO_LIMIT));
  assign bit_out  = raw_bit | (qrss_en & at_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (clr)      run_q <= '0;
    else if (step) begin
      if (bit_out)        run_q <= '0;
      else if (!at_limit) run_q <= run_q + RUN_W'(1);
    end
  end

  // R2: once the limit is reached, the next bit taken in QRSS mode ends the run
  assert_run_break_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qrss_en && step && !clr && at_limit) |=> (run_q == '0));

  // R2: the run counter never passes the limit
  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(ZERO_LIMIT));

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_pkg::*;
#(
  parameter int ZERO_LIMIT = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       load_req,
  input  logic [2:0] pat_sel,
  input  logic       inv_en,
  output logic       dout
);

  pat_sel_e mode_q;
  poly_t    poly;
  logic     load_rise;
  logic     take;
  logic     fb_bit;
  logic     lim_bit;
  logic     pat_bit;

  prbs_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (load_req),
    .rise  (load_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= SEL_P7;
    else if (load_rise) mode_q <= pat_sel_e'(pat_sel);
  end

  assign poly = decode_sel(mode_q);
  assign take = bit_en & poly.active & ~load_rise;

  prbs_lfsr_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed   (load_rise),
    .step   (take),
    .poly   (poly),
    .fb_bit (fb_bit)
  );

  prbs_zero_limit #(.ZERO_LIMIT(ZERO_LIMIT)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load_rise),
    .step    (take),
    .qrss_en (poly.qrss),
    .raw_bit (fb_bit),
    .bit_out (lim_bit)
  );

  assign pat_bit = poly.active ? lim_bit : 1'b1;
  assign dout    = pat_bit ^ inv_en;

  // R6: a reserved mode with no load edge keeps the pattern bit at one in the next cycle
  assert_reserved_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!poly.active && !load_rise) |=> ((dout ^ inv_en) == 1'b1));

  // R4: the first pseudorandom bit after a load is zero
  assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && (pat_sel_e'(pat_sel) inside {SEL_P7, SEL_P9, SEL_P11, SEL_P15, SEL_QRSS}))
    |=> ((dout ^ inv_en) == 1'b0));

endmodule

// File: tb/prbs_pattern_gen_tb.sv
`timescale 1ns/1ps
module prbs_pattern_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n, bit_en, load_req, inv_en;
  logic [2:0] pat_sel;
  logic       dout;

  always #2.5 clk = ~clk;

  prbs_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load_req(load_req),
    .pat_sel(pat_sel), .inv_en(inv_en), .dout(dout)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string ctx     = "R8";
  logic  last_obs;

  // behavioural reference: history of emitted raw bits
  bit hist[$];
  int m_len, m_tap, m_run;
  bit m_act, m_qrss, m_prev_load;

  function void m_decode(logic [2:0] s);
    m_act = 1; m_qrss = 0;
    case (s)
      3'b000: begin m_len = 7;  m_tap = 6;  end
      3'b111: begin m_len = 9;  m_tap = 5;  end
      3'b001: begin m_len = 11; m_tap = 9;  end
      3'b010: begin m_len = 15; m_tap = 14; end
      3'b011: begin m_len = 20; m_tap = 17; m_qrss = 1; end
      default: begin m_len = 7; m_tap = 6; m_act = 0; end
    endcase
  endfunction

  function void m_seed();
    hist.delete();
    for (int i = 0; i < m_len; i++) hist.push_back(1'b1);
    m_run = 0;
  endfunction

  function bit m_fb();
    return hist[hist.size() - m_len] ^ hist[hist.size() - m_tap];
  endfunction

  function bit m_out();
    bit b;
    if (!m_act) return 1'b1;
    b = m_fb();
    if (m_qrss && !b && m_run == 14) return 1'b1;
    return b;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one clock: drive after negedge, compare 1 ns later, update model at posedge
  task automatic cyc(input logic en, input logic ld, input logic [2:0] s, input logic inv);
    bit o, f;
    bit_en = en; load_req = ld; pat_sel = s; inv_en = inv;
    #1;
    check(ctx, dout, m_out() ^ inv);
    last_obs = dout ^ inv;
    @(posedge clk);
    if (ld && !m_prev_load) begin
      m_decode(s);
      m_seed();
    end else if (en && m_act) begin
      o = m_out();
      f = m_fb();
      hist.push_back(f);
      void'(hist.pop_front());
      m_run = o ? 0 : ((m_run < 14) ? m_run + 1 : m_run);
    end
    m_prev_load = ld;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] s);
    cyc(1'b0, 1'b1, s, 1'b0);
    cyc(1'b0, 1'b0, s, 1'b0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic obs[$];
    int   zr, zmax, forced_like;
    bit   ok;
    rst_n = 0; bit_en = 0; load_req = 0; pat_sel = 3'b000; inv_en = 0;
    m_decode(3'b000); m_seed(); m_prev_load = 0;
    repeat (3) @(negedge clk);
    check("R8", dout, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R8", dout, 1'b0);

    // R1 / R9: default 2^7-1 stream and its period
    ctx = "R1";
    obs.delete();
    for (int i = 0; i < 254; i++) begin cyc(1, 0, 3'b000, 0); obs.push_back(last_obs); end
    ok = 1;
    for (int i = 0; i < 127; i++) if (obs[i] !== obs[i+127]) ok = 0;
    check("R9 period 127", ok, 1'b1);
    ok = 0;
    for (int i = 1; i < 127; i++) if (obs[i] !== obs[0]) ok = 1;
    check("R9 not constant", ok, 1'b1);

    // R5: irregular bit_en stalls the stream without loss
    ctx = "R5";
    for (int i = 0; i < 400; i++) cyc(logic'($urandom_range(0, 1)), 0, 3'b000, 0);

    // R3: select change without a load edge is ignored
    ctx = "R3";
    for (int i = 0; i < 60; i++) cyc(1, 0, 3'b010, 0);

    // R1 / R4 / R9: 2^9-1 after a load, period 511
    ctx = "R4";
    cyc(0, 1, 3'b111, 0);
    check("R4 first bit", dout, 1'b0);
    ctx = "R1";
    obs.delete();
    for (int i = 0; i < 1022; i++) begin cyc(1, 0, 3'b111, 0); obs.push_back(last_obs); end
    ok = 1;
    for (int i = 0; i < 511; i++) if (obs[i] !== obs[i+511]) ok = 0;
    check("R9 period 511", ok, 1'b1);

    // R1: 2^11-1 and 2^15-1
    do_load(3'b001);
    for (int i = 0; i < 500; i++) cyc(1, 0, 3'b001, 0);
    do_load(3'b010);
    for (int i = 0; i < 500; i++) cyc(1, 0, 3'b010, 0);

    // R3: load held high with bit_en active gives one load only
    ctx = "R3";
    for (int i = 0; i < 80; i++) cyc(1, 1, (i < 40) ? 3'b000 : 3'b001, 0);
    cyc(1, 0, 3'b001, 0);
    for (int i = 0; i < 20; i++) cyc(1, 0, 3'b001, 0);

    // R5: load and bit_en in the same cycle, load wins
    ctx = "R5";
    cyc(1, 1, 3'b000, 0);
    check("R5 load priority", dout, 1'b0);
    for (int i = 0; i < 30; i++) cyc(1, 0, 3'b000, 0);

    // R7: invert toggling on a live stream
    ctx = "R7";
    for (int i = 0; i < 200; i++) cyc(1, 0, 3'b000, logic'(i[2]));

    // R6: reserved codes idle at one, inverted gives zero
    ctx = "R6";
    for (int c = 4; c < 7; c++) begin
      do_load(3'(c));
      check("R6 idle one", dout, 1'b1);
      for (int i = 0; i < 40; i++) cyc(logic'(i[0]), 0, 3'(c), logic'(i[3]));
    end

    // R2: long QRSS run, zero runs limited at the port
    ctx = "R2";
    do_load(3'b011);
    zr = 0; zmax = 0; forced_like = 0;
    for (int i = 0; i < 150000; i++) begin
      cyc(1, 0, 3'b011, 0);
      if (last_obs == 1'b0) zr++;
      else begin
        if (zr == 14) forced_like++;
        zr = 0;
      end
      if (zr > zmax) zmax = zr;
    end
    check("R2 max zero run", logic'(zmax <= 14), 1'b1);
    $display("  [TB] QRSS longest zero run %0d, runs of 14 seen %0d", zmax, forced_like);

    finish_up();
  end

endmodule